// File: doc/BRIEF.md
# DRAM Command Selection Multiplexer

This block sits at the heart of a DRAM controller's issue stage. It sees a set of candidate commands every cycle. For each rank there is one candidate from the power-down manager, one from the refresh manager, and one from each bank of the rank. The block picks at most one of them for the command bus, or issues nothing. A candidate is a command code plus a ready time. Bank candidates also carry a 64-bit request sequence ID. Refresh candidates use a fixed ID set by a parameter. Power-down candidates use the all-ones ID.

A ready-time filter comes before the choice. It only admits candidates whose scheduled time equals the current time count. Two policies are selected by a mode input:

- **Oldest-first** takes the smallest sequence ID.
- **Strict in-order** issues column commands only in ascending ID order, using an internal expected-ID counter. When no column command matches, the first row-type command is let through.

The choice is registered and presented with a one-cycle valid strobe, together with the rank, bank and ID of the winner.

Top module: `cmd_sel_mux`

## Requirements
- R1: During and right after reset, out_valid is 0, out_cmd is NOP (code 0), out_rank, out_bank and out_id are 0, and the expected column ID of strict mode is 0.
- R2: For a rank whose power-down input is not NOP, only the power-down candidate is considered from that rank. The rank's refresh and bank candidates are hidden even when that power-down command is not ready in the current cycle.
- R3: A candidate is considered only if its code is not NOP and its ready time equals now_time.
- R4: In oldest mode (strict_mode=0), the considered candidate with the smallest ID wins, compared as unsigned 64-bit values. On equal IDs, the lowest candidate index wins. Candidate index order is rank by rank, ascending; within a rank the power-down slot comes first, then the refresh slot, then banks 0 upward.
- R5: A refresh candidate carries ID REF_ID (default 0). A power-down candidate carries ID all ones, so in oldest mode it loses to any real request with a smaller ID.
- R6: In strict mode (strict_mode=1), a column command (RD=4, WR=5, RDA=6, WRA=7) is chosen only if its ID equals the expected ID. Each such issue raises the expected ID by exactly one. No other event changes it, in either mode.
- R7: In strict mode, when no column command matches, the lowest-index considered row-type command is chosen. A row-type command is any code that is neither NOP nor a column code (ACT=1, PRE=2, PREA=3, refresh 8–9, power-down 10–15).
- R8: When no candidate qualifies, the next output has out_valid=0 and out_cmd=NOP. In strict mode this also holds when only non-matching column commands are ready.
- R9: The choice made from the inputs at a clock edge appears on the outputs after that edge and holds for one cycle only. out_valid is high in exactly the cycles that follow an edge where a command was chosen.
- R10: With a valid output, out_rank gives the winner's rank and out_id gives its ID. out_bank gives the bank index within the rank for bank commands, and 0 for refresh and power-down commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strict_mode | input | 1 | 1 selects strict in-order, 0 selects oldest-first |
| now_time | input | TIME_W | Current time count compared against ready times |
| pd_cmd | input | NUM_RANKS*4 | Power-down candidate code per rank |
| pd_time | input | NUM_RANKS*TIME_W | Power-down ready time per rank |
| ref_cmd | input | NUM_RANKS*4 | Refresh candidate code per rank |
| ref_time | input | NUM_RANKS*TIME_W | Refresh ready time per rank |
| bank_cmd | input | NUM_RANKS*BANKS*4 | Bank candidate code, rank-major |
| bank_id | input | NUM_RANKS*BANKS*ID_W | Bank candidate sequence ID |
| bank_time | input | NUM_RANKS*BANKS*TIME_W | Bank candidate ready time |
| out_valid | output | 1 | One-cycle strobe: a command is issued |
| out_cmd | output | 4 | Issued command code, NOP when idle |
| out_rank | output | RANK_W | Rank of the issued command |
| out_bank | output | BANK_W | Bank within rank of the issued command |
| out_id | output | ID_W | Sequence ID of the issued command |

## Verification
In strict mode, a matching column command and a row-type command can be ready in the same cycle. The bench provokes this by placing an ACT or PRE at a lower candidate index than a column command. First the column ID equals the expected ID, then it does not. The column command must win in the first case and the row command in the second, and the expected ID may only advance in the first. A second collision, between a pending but unready power-down command and ready bank commands on the same rank, is provoked alongside ready work on the other rank. Every cycle is judged against a behavioural reference model that gathers and ranks candidates from the requirements.

// File: rtl/cmdsel_pkg.sv
// Package: shared command codes and classification helpers for the
// command selection multiplexer. Assumes a 4-bit command code.
package cmdsel_pkg;
    localparam int CMD_W = 4;

    localparam logic [CMD_W-1:0] CMD_NOP   = 4'd0;
    localparam logic [CMD_W-1:0] CMD_ACT   = 4'd1;
    localparam logic [CMD_W-1:0] CMD_PRE   = 4'd2;
    localparam logic [CMD_W-1:0] CMD_PREA  = 4'd3;
    localparam logic [CMD_W-1:0] CMD_RD    = 4'd4;
    localparam logic [CMD_W-1:0] CMD_WR    = 4'd5;
    localparam logic [CMD_W-1:0] CMD_RDA   = 4'd6;
    localparam logic [CMD_W-1:0] CMD_WRA   = 4'd7;
    localparam logic [CMD_W-1:0] CMD_REFA  = 4'd8;
    localparam logic [CMD_W-1:0] CMD_REFB  = 4'd9;
    localparam logic [CMD_W-1:0] CMD_PDEA  = 4'd10;
    localparam logic [CMD_W-1:0] CMD_PDXA  = 4'd11;

    // Column (data-moving) commands occupy codes RD..WRA.
    function automatic logic cmd_is_column(input logic [CMD_W-1:0] c);
        return (c >= CMD_RD) && (c <= CMD_WRA);
    endfunction
endpackage

// File: rtl/cmdsel_gather.sv
// Module: cmdsel_gather
// Builds the flat candidate list, rank by rank. Each rank contributes
// slots in the order power-down, refresh, then banks 0..BANKS-1.
// A slot is marked eligible when its code is not NOP and its ready time
// equals now_time. A non-NOP power-down code hides the rest of its rank,
// whether or not that power-down command is itself ready.
// Assumes the flat input buses are packed rank-major.
module cmdsel_gather
    import cmdsel_pkg::*;
#(
    parameter int NUM_RANKS = 2,
    parameter int BANKS     = 4,
    parameter int ID_W      = 64,
    parameter int TIME_W    = 16,
    parameter logic [63:0] REF_ID = 64'd0,
    localparam int SLOTS    = BANKS + 2,
    localparam int N        = NUM_RANKS * SLOTS,
    localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int BANK_W   = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic [TIME_W-1:0]                now_time,
    input  logic [NUM_RANKS*CMD_W-1:0]       pd_cmd,
    input  logic [NUM_RANKS*TIME_W-1:0]      pd_time,
    input  logic [NUM_RANKS*CMD_W-1:0]       ref_cmd,
    input  logic [NUM_RANKS*TIME_W-1:0]      ref_time,
    input  logic [NUM_RANKS*BANKS*CMD_W-1:0] bank_cmd,
    input  logic [NUM_RANKS*BANKS*ID_W-1:0]  bank_id,
    input  logic [NUM_RANKS*BANKS*TIME_W-1:0] bank_time,
    output logic                             cand_ok   [N],
    output logic [CMD_W-1:0]                 cand_cmd  [N],
    output logic [ID_W-1:0]                  cand_id   [N],
    output logic [RANK_W-1:0]                cand_rank [N],
    output logic [BANK_W-1:0]                cand_bank [N]
);
    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        localparam int BASE = r * SLOTS;
        logic [CMD_W-1:0] pd_c;
        logic [CMD_W-1:0] rf_c;
        logic             pd_pending;

        // Slice this rank's rank-level fields.
        assign pd_c       = pd_cmd[r*CMD_W +: CMD_W];
        assign rf_c       = ref_cmd[r*CMD_W +: CMD_W];
        assign pd_pending = (pd_c != CMD_NOP);

        // Power-down slot: fixed all-ones ID.
        assign cand_ok[BASE]   = pd_pending && (pd_time[r*TIME_W +: TIME_W] == now_time);
        assign cand_cmd[BASE]  = pd_c;
        assign cand_id[BASE]   = '1;
        assign cand_rank[BASE] = RANK_W'(r);
        assign cand_bank[BASE] = '0;

        // Refresh slot: fixed parameter ID, hidden by a pending power-down.
        assign cand_ok[BASE+1]   = !pd_pending && (rf_c != CMD_NOP) &&
                                   (ref_time[r*TIME_W +: TIME_W] == now_time);
        assign cand_cmd[BASE+1]  = rf_c;
        assign cand_id[BASE+1]   = ID_W'(REF_ID);
        assign cand_rank[BASE+1] = RANK_W'(r);
        assign cand_bank[BASE+1] = '0;

        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            localparam int K = r * BANKS + b;
            // Bank slot: own ID, hidden by a pending power-down.
            assign cand_ok[BASE+2+b]   = !pd_pending &&
                                         (bank_cmd[K*CMD_W +: CMD_W] != CMD_NOP) &&
                                         (bank_time[K*TIME_W +: TIME_W] == now_time);
            assign cand_cmd[BASE+2+b]  = bank_cmd[K*CMD_W +: CMD_W];
            assign cand_id[BASE+2+b]   = bank_id[K*ID_W +: ID_W];
            assign cand_rank[BASE+2+b] = RANK_W'(r);
            assign cand_bank[BASE+2+b] = BANK_W'(b);
        end
    end
endmodule

// File: rtl/cmdsel_pick.sv
// Module: cmdsel_pick
// Chooses one eligible candidate per cycle, combinationally.
// Oldest mode: smallest unsigned ID, lowest index on ties.
// Strict mode: the lowest-index column command whose ID matches exp_id;
// failing that, the lowest-index row-type command; failing that, none.
// clk and rst_n serve only the assertions placed here.
module cmdsel_pick
    import cmdsel_pkg::*;
#(
    parameter int N     = 12,
    parameter int ID_W  = 64,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strict,
    input  logic [ID_W-1:0]  exp_id,
    input  logic             cand_ok  [N],
    input  logic [CMD_W-1:0] cand_cmd [N],
    input  logic [ID_W-1:0]  cand_id  [N],
    output logic             pick_valid,
    output logic [IDX_W-1:0] pick_idx,
    output logic             pick_col
);
    logic             old_hit, col_hit, row_hit;
    logic [IDX_W-1:0] old_idx, col_idx, row_idx;
    logic [ID_W-1:0]  old_best;

    // Scan all candidates for the three policy results.
    always_comb begin
        old_hit  = 1'b0;
        old_idx  = '0;
        old_best = '1;
        col_hit  = 1'b0;
        col_idx  = '0;
        row_hit  = 1'b0;
        row_idx  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand_ok[i] && (!old_hit || (cand_id[i] < old_best))) begin
                old_hit  = 1'b1;
                old_best = cand_id[i];
                old_idx  = IDX_W'(i);
            end
            if (!col_hit && cand_ok[i] && cmd_is_column(cand_cmd[i]) &&
                (cand_id[i] == exp_id)) begin
                col_hit = 1'b1;
                col_idx = IDX_W'(i);
            end
            if (!row_hit && cand_ok[i] && !cmd_is_column(cand_cmd[i])) begin
                row_hit = 1'b1;
                row_idx = IDX_W'(i);
            end
        end
    end

    // Resolve the active policy.
    always_comb begin
        pick_col = 1'b0;
        if (strict) begin
            if (col_hit) begin
                pick_valid = 1'b1;
                pick_idx   = col_idx;
                pick_col   = 1'b1;
            end else begin
                pick_valid = row_hit;
                pick_idx   = row_idx;
            end
        end else begin
            pick_valid = old_hit;
            pick_idx   = old_idx;
        end
    end

    // Independent search for a better oldest-mode winner than the one picked.
    logic better_exists;
    always_comb begin
        better_exists = 1'b0;
        for (int j = 0; j < N; j++) begin
            if (cand_ok[j] && ((cand_id[j] < cand_id[pick_idx]) ||
                ((cand_id[j] == cand_id[pick_idx]) && (IDX_W'(j) < pick_idx))))
                better_exists = 1'b1;
        end
    end

    AST_OLDEST_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_valid && !strict) |-> !better_exists) else $error("oldest pick not minimal"); // R4

    AST_STRICT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_valid && strict && cmd_is_column(cand_cmd[pick_idx])) |-> (cand_id[pick_idx] == exp_id))
        else $error("strict column out of order"); // R6

    AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> cand_ok[pick_idx]) else $error("picked an ineligible slot"); // R3
endmodule

// File: rtl/cmd_sel_mux.sv
// Module: cmd_sel_mux (top)
// Gathers power-down, refresh and bank candidates for every rank, filters
// them by ready time, and picks at most one command per cycle under the
// oldest-first or strict in-order policy. The result is registered, with a
// one-cycle valid strobe. The expected column ID of strict mode lives here.
// Assumes a synchronous active-low reset.
module cmd_sel_mux
    import cmdsel_pkg::*;
#(
    parameter int NUM_RANKS = 2,
    parameter int BANKS     = 4,
    parameter int ID_W      = 64,
    parameter int TIME_W    = 16,
    parameter logic [63:0] REF_ID = 64'd0,
    localparam int N        = NUM_RANKS * (BANKS + 2),
    localparam int IDX_W    = (N > 1) ? $clog2(N) : 1,
    localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int BANK_W   = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              strict_mode,
    input  logic [TIME_W-1:0]                 now_time,
    input  logic [NUM_RANKS*CMD_W-1:0]        pd_cmd,
    input  logic [NUM_RANKS*TIME_W-1:0]       pd_time,
    input  logic [NUM_RANKS*CMD_W-1:0]        ref_cmd,
    input  logic [NUM_RANKS*TIME_W-1:0]       ref_time,
    input  logic [NUM_RANKS*BANKS*CMD_W-1:0]  bank_cmd,
    input  logic [NUM_RANKS*BANKS*ID_W-1:0]   bank_id,
    input  logic [NUM_RANKS*BANKS*TIME_W-1:0] bank_time,
    output logic                              out_valid,
    output logic [CMD_W-1:0]                  out_cmd,
    output logic [RANK_W-1:0]                 out_rank,
    output logic [BANK_W-1:0]                 out_bank,
    output logic [ID_W-1:0]                   out_id
);
    logic             cand_ok   [N];
    logic [CMD_W-1:0] cand_cmd  [N];
    logic [ID_W-1:0]  cand_id   [N];
    logic [RANK_W-1:0] cand_rank [N];
    logic [BANK_W-1:0] cand_bank [N];
    logic             pick_valid, pick_col;
    logic [IDX_W-1:0] pick_idx;
    logic [ID_W-1:0]  exp_id;

    cmdsel_gather #(
        .NUM_RANKS(NUM_RANKS), .BANKS(BANKS), .ID_W(ID_W),
        .TIME_W(TIME_W), .REF_ID(REF_ID)
    ) u_gather (
        .now_time(now_time), .pd_cmd(pd_cmd), .pd_time(pd_time),
        .ref_cmd(ref_cmd), .ref_time(ref_time), .bank_cmd(bank_cmd),
        .bank_id(bank_id), .bank_time(bank_time),
        .cand_ok(cand_ok), .cand_cmd(cand_cmd), .cand_id(cand_id),
        .cand_rank(cand_rank), .cand_bank(cand_bank)
    );

    cmdsel_pick #(.N(N), .ID_W(ID_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .strict(strict_mode), .exp_id(exp_id),
        .cand_ok(cand_ok), .cand_cmd(cand_cmd), .cand_id(cand_id),
        .pick_valid(pick_valid), .pick_idx(pick_idx), .pick_col(pick_col)
    );

    // Register the chosen command and advance the expected column ID.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_cmd   <= CMD_NOP;
            out_rank  <= '0;
            out_bank  <= '0;
            out_id    <= '0;
            exp_id    <= '0;
        end else begin
            out_valid <= pick_valid;
            out_cmd   <= pick_valid ? cand_cmd[pick_idx]  : CMD_NOP;
            out_rank  <= pick_valid ? cand_rank[pick_idx] : '0;
            out_bank  <= pick_valid ? cand_bank[pick_idx] : '0;
            out_id    <= pick_valid ? cand_id[pick_idx]   : '0;
            if (pick_col)
                exp_id <= exp_id + 1'b1;
        end
    end

    AST_VALID_NOT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cmd != CMD_NOP)) else $error("valid with NOP"); // R8

    AST_EXP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_id == $past(exp_id)) || (exp_id == $past(exp_id) + 1'b1))
        else $error("expected ID jumped"); // R6

    AST_STRICT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(strict_mode) && cmd_is_column(out_cmd)) |-> (out_id == exp_id - 1'b1))
        else $error("strict column issued with wrong ID"); // R6
endmodule

// File: tb/sim_cmd_sel_mux.sv
// Bench: drives candidate sets, predicts each registered output with a
// behavioural model and compares every clock.
module sim_cmd_sel_mux;
    localparam int R = 2, B = 4, IDW = 64, TW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strict_mode = 1'b0;
    logic [TW-1:0] now_time;
    logic [3:0]    pdc [R];
    logic [TW-1:0] pdt [R];
    logic [3:0]    rfc [R];
    logic [TW-1:0] rft [R];
    logic [3:0]    bkc [R*B];
    logic [IDW-1:0] bki [R*B];
    logic [TW-1:0] bkt [R*B];

    logic [R*4-1:0]    pd_cmd, ref_cmd;
    logic [R*TW-1:0]   pd_time, ref_time;
    logic [R*B*4-1:0]  bank_cmd;
    logic [R*B*IDW-1:0] bank_id;
    logic [R*B*TW-1:0] bank_time;

    logic           out_valid;
    logic [3:0]     out_cmd;
    logic [0:0]     out_rank;
    logic [1:0]     out_bank;
    logic [IDW-1:0] out_id;

    int tests = 0, fails = 0;
    int tnow = 100;
    logic [IDW-1:0] m_exp = '0;
    logic           e_valid;
    logic [3:0]     e_cmd;
    int             e_rank, e_bank;
    logic [IDW-1:0] e_id;

    always #5 clk = ~clk;

    always_comb begin
        for (int r = 0; r < R; r++) begin
            pd_cmd[r*4 +: 4]    = pdc[r];
            pd_time[r*TW +: TW] = pdt[r];
            ref_cmd[r*4 +: 4]   = rfc[r];
            ref_time[r*TW +: TW] = rft[r];
        end
        for (int k = 0; k < R*B; k++) begin
            bank_cmd[k*4 +: 4]      = bkc[k];
            bank_id[k*IDW +: IDW]   = bki[k];
            bank_time[k*TW +: TW]   = bkt[k];
        end
    end
    assign now_time = TW'(tnow);

    cmd_sel_mux u0 (
        .clk(clk), .rst_n(rst_n), .strict_mode(strict_mode), .now_time(now_time),
        .pd_cmd(pd_cmd), .pd_time(pd_time), .ref_cmd(ref_cmd), .ref_time(ref_time),
        .bank_cmd(bank_cmd), .bank_id(bank_id), .bank_time(bank_time),
        .out_valid(out_valid), .out_cmd(out_cmd), .out_rank(out_rank),
        .out_bank(out_bank), .out_id(out_id)
    );

    function automatic bit is_col(logic [3:0] c);
        return c >= 4 && c <= 7;
    endfunction

    task automatic clear_all();
        for (int r = 0; r < R; r++) begin
            pdc[r] = 0; pdt[r] = TW'(tnow); rfc[r] = 0; rft[r] = TW'(tnow);
        end
        for (int k = 0; k < R*B; k++) begin
            bkc[k] = 0; bki[k] = 0; bkt[k] = TW'(tnow);
        end
    endtask

    task automatic set_bank(int r, int b, logic [3:0] c, logic [IDW-1:0] id, int dt);
        bkc[r*B+b] = c; bki[r*B+b] = id; bkt[r*B+b] = TW'(tnow + dt);
    endtask

    // Behavioural prediction from the requirements.
    task automatic predict();
        logic [3:0] qc[$];
        logic [IDW-1:0] qi[$];
        int qr[$], qb[$];
        int sel;
        for (int r = 0; r < R; r++) begin
            if (pdc[r] != 0) begin
                if (pdt[r] == TW'(tnow)) begin
                    qc.push_back(pdc[r]); qi.push_back('1); qr.push_back(r); qb.push_back(0);
                end
            end else begin
                if (rfc[r] != 0 && rft[r] == TW'(tnow)) begin
                    qc.push_back(rfc[r]); qi.push_back('0); qr.push_back(r); qb.push_back(0);
                end
                for (int b = 0; b < B; b++)
                    if (bkc[r*B+b] != 0 && bkt[r*B+b] == TW'(tnow)) begin
                        qc.push_back(bkc[r*B+b]); qi.push_back(bki[r*B+b]);
                        qr.push_back(r); qb.push_back(b);
                    end
            end
        end
        sel = -1;
        if (!strict_mode) begin
            for (int i = 0; i < qc.size(); i++)
                if (sel < 0 || qi[i] < qi[sel]) sel = i;
        end else begin
            for (int i = 0; i < qc.size(); i++)
                if (sel < 0 && is_col(qc[i]) && qi[i] == m_exp) sel = i;
            if (sel >= 0) m_exp = m_exp + 1;
            else
                for (int i = 0; i < qc.size(); i++)
                    if (sel < 0 && !is_col(qc[i])) sel = i;
        end
        e_valid = (sel >= 0);
        e_cmd   = (sel >= 0) ? qc[sel] : 4'd0;
        e_rank  = (sel >= 0) ? qr[sel] : 0;
        e_bank  = (sel >= 0) ? qb[sel] : 0;
        e_id    = (sel >= 0) ? qi[sel] : '0;
    endtask

    task automatic compare(string tag);
        tests++;
        if (out_valid !== e_valid || out_cmd !== e_cmd || int'(out_rank) != e_rank ||
            int'(out_bank) != e_bank || out_id !== e_id) begin
            fails++;
            $display("FAIL %s: got v=%0b cmd=%0d rk=%0d bk=%0d id=%0h exp v=%0b cmd=%0d rk=%0d bk=%0d id=%0h",
                     tag, out_valid, out_cmd, out_rank, out_bank, out_id,
                     e_valid, e_cmd, e_rank, e_bank, e_id);
        end
    endtask

    // One clock: predict from current inputs, sample after the edge.
    task automatic tick(string tag);
        predict();
        @(posedge clk); #1;
        compare(tag);
        tnow++;
        clear_all();
    endtask

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        clear_all();
        repeat (3) @(posedge clk);
        #1;
        e_valid = 0; e_cmd = 0; e_rank = 0; e_bank = 0; e_id = 0;
        compare("R1 reset");
        rst_n = 1'b1;
        tick("R1 idle after reset");

        // Oldest mode
        strict_mode = 1'b0;
        set_bank(0, 0, 4'd4, 64'd5, 0); set_bank(0, 2, 4'd1, 64'd3, 0); set_bank(1, 1, 4'd5, 64'd9, 0);
        tick("R4 smallest id");
        set_bank(0, 1, 4'd4, 64'd7, 0); set_bank(1, 3, 4'd5, 64'd7, 0);
        tick("R4 tie lowest index");
        set_bank(0, 0, 4'd4, 64'd1, 1); set_bank(0, 3, 4'd4, 64'd8, 0);
        tick("R3 ready time filter");
        set_bank(1, 0, 4'd0, 64'd0, 0); set_bank(1, 2, 4'd2, 64'd11, 0);
        tick("R3 nop excluded");
        rfc[1] = 4'd8; set_bank(1, 0, 4'd4, 64'd2, 0);
        tick("R5 refresh id zero");
        pdc[0] = 4'd10; set_bank(1, 1, 4'd4, 64'd100, 0);
        tick("R5 power-down loses");
        pdc[0] = 4'd11; set_bank(0, 1, 4'd4, 64'd1, 0); rfc[0] = 4'd9;
        tick("R2 power-down hides rank");
        pdc[0] = 4'd11; pdt[0] = TW'(tnow + 1); set_bank(0, 1, 4'd4, 64'd1, 0);
        tick("R2 unready power-down hides rank");
        pdc[0] = 4'd10; pdt[0] = TW'(tnow + 1); set_bank(0, 1, 4'd4, 64'd1, 0);
        set_bank(1, 2, 4'd5, 64'd50, 0);
        tick("R2 other rank still served");
        set_bank(0, 0, 4'd4, 64'h8000_0000_0000_0000, 0); set_bank(0, 1, 4'd5, 64'h7FFF_FFFF_FFFF_FFFF, 0);
        tick("R4 unsigned compare");
        set_bank(1, 3, 4'd6, 64'd42, 0);
        tick("R10 tags rank1 bank3");
        tick("R9 valid drops after one cycle");

        // Strict mode
        strict_mode = 1'b1;
        set_bank(0, 0, 4'd1, 64'd20, 0); set_bank(0, 3, 4'd4, 64'd0, 0);
        tick("R6 matching column beats row");
        set_bank(0, 0, 4'd2, 64'd21, 0); set_bank(0, 3, 4'd4, 64'd2, 0);
        tick("R7 row when column mismatches");
        set_bank(1, 1, 4'd5, 64'd2, 0);
        tick("R8 strict nothing qualifies");
        set_bank(0, 2, 4'd7, 64'd1, 0); set_bank(1, 0, 4'd5, 64'd0, 0);
        tick("R6 expected id one");
        rfc[1] = 4'd8; set_bank(1, 1, 4'd1, 64'd3, 0);
        tick("R7 first row-type command");
        set_bank(1, 2, 4'd4, 64'd2, 1);
        tick("R8 matching column not ready");
        strict_mode = 1'b0; set_bank(0, 0, 4'd4, 64'd9, 0);
        tick("R6 oldest issue keeps counter");
        strict_mode = 1'b1; set_bank(0, 0, 4'd4, 64'd2, 0);
        tick("R6 counter held across mode switch");

        // Mixed sweep in both modes
        for (int n = 0; n < 400; n++) begin
            strict_mode = (n >= 200);
            for (int r = 0; r < R; r++) begin
                pdc[r] = (($urandom % 8) == 0) ? 4'(10 + $urandom % 6) : 4'd0;
                pdt[r] = TW'(tnow + ($urandom % 2));
                rfc[r] = (($urandom % 4) == 0) ? 4'd8 : 4'd0;
                rft[r] = TW'(tnow + ($urandom % 2));
            end
            for (int k = 0; k < R*B; k++) begin
                bkc[k] = 4'($urandom % 8);
                bki[k] = strict_mode ? (m_exp + 64'($urandom % 4)) : 64'($urandom % 16);
                bkt[k] = TW'(tnow + (($urandom % 3) == 0 ? 1 : 0));
            end
            tick(strict_mode ? "R7 strict sweep" : "R4 oldest sweep");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule